// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the processor status byte of a small 8-bit microcontroller core. Four arithmetic flags (carry, auxiliary carry, zero, overflow) are refreshed from the carry information and result that the ALU presents with each operation. Two system flags record whether the core has been halted and whether the watchdog has expired. They change only on reset, a watchdog expiry, a clear-watchdog instruction or a halt instruction.

Every operation arrives as one cycle of strobes. The block samples these strobes on a rising clock edge, and the packed byte shows the new value after that edge. Software can load the four arithmetic flags directly. Software cannot reach the two system flags. The register is not saved on calls or interrupt entry. Any handler that needs it must save it.

Top module: `psr_status_reg`

## Requirements
- R1: The status layout is: bit 0 carry, bit 1 auxiliary carry, bit 2 zero, bit 3 overflow, bit 4 power-down, bit 5 time-out. Bits 7:6 always read 0. A synchronous reset clears every bit. Any update becomes visible on `status` one clock edge after the inputs are sampled.
- R2: For the add class (`alu_class` = 0), carry takes `alu_c_out` and auxiliary carry takes `alu_c_nib`. Overflow is `alu_c_msb` XOR `alu_c_out`.
- R3: For the subtract class (`alu_class` = 1), the three carry inputs carry borrows. Carry is the inverse of `alu_c_out`, so it is set when no borrow occurs. Auxiliary carry is the inverse of `alu_c_nib`. Overflow is `alu_c_msb` XOR `alu_c_out`.
- R4: For the add, subtract and logic classes, zero is set exactly when `alu_result` is all zeros.
- R5: The logic class (`alu_class` = 2) touches only zero. The rotate class (`alu_class` = 3) touches only carry, which takes the shifted-out bit on `alu_c_out`.
- R6: Bit n of `alu_flag_en` gates the update of status bit n (n = 0..3). A flag whose enable is clear keeps its value. Nothing changes while `alu_valid` is low.
- R7: A software write loads status bits 3:0 from `sw_wdata[3:0]`. Bits 7:4 of the write data are ignored. In the same cycle, a software write takes priority over an ALU update.
- R8: Power-down is set by `halt` and cleared by `clr_wdt` or reset. When both instructions arrive together, the halt wins.
- R9: Time-out is set by `wdt_timeout` and cleared by `clr_wdt` or `halt`. An expiry in the same cycle as a clear leaves time-out set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| alu_valid | input | 1 | An ALU operation completes this cycle |
| alu_class | input | 2 | Operation class: 0 add, 1 subtract, 2 logic, 3 rotate |
| alu_result | input | 8 | ALU result byte |
| alu_c_out | input | 1 | Carry/borrow out of bit 7, or the rotated-out bit |
| alu_c_nib | input | 1 | Carry/borrow out of bit 3 |
| alu_c_msb | input | 1 | Carry/borrow into bit 7 |
| alu_flag_en | input | 4 | Per-flag update enables, bit n for status bit n |
| wdt_timeout | input | 1 | Watchdog expiry strobe |
| clr_wdt | input | 1 | Clear-watchdog instruction strobe |
| halt | input | 1 | Halt instruction strobe |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 8 | Software write data |
| status | output | 8 | Packed status byte |

## Verification
The bench targets the inverted carry on subtraction. A design that copied the borrow straight through would report carry set exactly when a borrow happened. It checks that logic and rotate operations spare the flags they do not own. A design that dropped the class mask would wipe carry or overflow after a logical AND. It drives coincident events: an expiry with a clear, a halt with a clear, and a software write with an ALU result. A wrong priority order would lose the expiry, leave power-down clear after a halt, or let the ALU overwrite the written value. It also writes ones to the upper data bits. A design that let them through would flip the read-only system flags.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int STATUS_W = 8;
    localparam int ARITH_W  = 4;

    // Bit positions inside the status byte
    localparam int BIT_C   = 0;
    localparam int BIT_AC  = 1;
    localparam int BIT_Z   = 2;
    localparam int BIT_OV  = 3;
    localparam int BIT_PDF = 4;
    localparam int BIT_TO  = 5;

    typedef enum logic [1:0] {
        OP_ADD   = 2'd0,
        OP_SUB   = 2'd1,
        OP_LOGIC = 2'd2,
        OP_ROT   = 2'd3
    } op_class_e;

    // Packed so that .c lands on bit 0 and .ov on bit 3
    typedef struct packed {
        logic ov;
        logic z;
        logic ac;
        logic c;
    } arith_flags_t;

    typedef struct packed {
        logic to;
        logic pdf;
    } sys_flags_t;

    // Which flags an operation class is allowed to touch
    function automatic logic [ARITH_W-1:0] class_mask(op_class_e k);
        logic [ARITH_W-1:0] m;
        m = '0;
        unique case (k)
            OP_ADD, OP_SUB: m = '1;
            OP_LOGIC:       m[BIT_Z] = 1'b1;
            OP_ROT:         m[BIT_C] = 1'b1;
            default:        m = '0;
        endcase
        return m;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(sys_flags_t s, arith_flags_t a);
        logic [STATUS_W-1:0] v;
        v = '0;
        v[ARITH_W-1:0] = a;
        v[BIT_PDF]     = s.pdf;
        v[BIT_TO]      = s.to;
        return v;
    endfunction

endpackage

// File: rtl/psr_arith_eval.sv
module psr_arith_eval
    import psr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 alu_valid,
    input  op_class_e            alu_class,
    input  logic [DATA_W-1:0]    alu_result,
    input  logic                 alu_c_out,
    input  logic                 alu_c_nib,
    input  logic                 alu_c_msb,
    input  logic [ARITH_W-1:0]   alu_flag_en,
    output arith_flags_t         cand,
    output logic [ARITH_W-1:0]   upd
);

    logic is_sub;
    logic res_zero;

    assign is_sub   = (alu_class == OP_SUB);
    assign res_zero = (alu_result == '0);

    always_comb begin
        // Subtraction presents borrows; flags hold "no borrow"
        cand.c  = is_sub ? ~alu_c_out : alu_c_out;
        cand.ac = is_sub ? ~alu_c_nib : alu_c_nib;
        cand.z  = res_zero;
        cand.ov = alu_c_msb ^ alu_c_out;
    end

    assign upd = alu_valid ? (class_mask(alu_class) & alu_flag_en) : '0;

endmodule

// File: rtl/psr_arith_reg.sv
module psr_arith_reg
    import psr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  arith_flags_t         cand,
    input  logic [ARITH_W-1:0]   upd,
    input  logic                 sw_we,
    input  logic [ARITH_W-1:0]   sw_data,
    output arith_flags_t         q
);

    logic [ARITH_W-1:0] cur;
    logic [ARITH_W-1:0] nxt;

    assign cur = q;

    generate
        for (genvar i = 0; i < ARITH_W; i++) begin : g_bit
            always_comb begin
                if (sw_we)
                    nxt[i] = sw_data[i];
                else if (upd[i])
                    nxt[i] = cand[i];
                else
                    nxt[i] = cur[i];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= arith_flags_t'(nxt);
    end

    // R7
    sw_load_chk: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (q == arith_flags_t'($past(sw_data))));

    // R6
    hold_c_chk: assert property (@(posedge clk) disable iff (rst)
        (!sw_we && !upd[BIT_C]) |=> (q.c == $past(q.c)));

endmodule

// File: rtl/psr_sys_flags.sv
module psr_sys_flags
    import psr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wdt_timeout,
    input  logic       clr_wdt,
    input  logic       halt,
    output sys_flags_t q
);

    sys_flags_t nxt;

    always_comb begin
        nxt = q;
        if (halt)
            nxt.pdf = 1'b1;
        else if (clr_wdt)
            nxt.pdf = 1'b0;

        if (wdt_timeout)
            nxt.to = 1'b1;
        else if (clr_wdt || halt)
            nxt.to = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end

    // R9
    to_set_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_timeout |=> q.to);

    // R9
    to_clr_chk: assert property (@(posedge clk) disable iff (rst)
        ((clr_wdt || halt) && !wdt_timeout) |=> !q.to);

    // R8
    pdf_set_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> q.pdf);

    // R8
    pdf_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_wdt && !halt) |=> !q.pdf);

endmodule

// File: rtl/psr_status_reg.sv
module psr_status_reg
    import psr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_valid,
    input  logic [1:0]        alu_class,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_c_out,
    input  logic              alu_c_nib,
    input  logic              alu_c_msb,
    input  logic [3:0]        alu_flag_en,
    input  logic              wdt_timeout,
    input  logic              clr_wdt,
    input  logic              halt,
    input  logic              sw_we,
    input  logic [7:0]        sw_wdata,
    output logic [7:0]        status
);

    arith_flags_t       cand;
    arith_flags_t       arith_q;
    logic [ARITH_W-1:0] upd;
    sys_flags_t         sys_q;

    psr_arith_eval #(.DATA_W(DATA_W)) u_eval (
        .alu_valid   (alu_valid),
        .alu_class   (op_class_e'(alu_class)),
        .alu_result  (alu_result),
        .alu_c_out   (alu_c_out),
        .alu_c_nib   (alu_c_nib),
        .alu_c_msb   (alu_c_msb),
        .alu_flag_en (alu_flag_en),
        .cand        (cand),
        .upd         (upd)
    );

    psr_arith_reg u_arith (
        .clk     (clk),
        .rst     (rst),
        .cand    (cand),
        .upd     (upd),
        .sw_we   (sw_we),
        .sw_data (sw_wdata[ARITH_W-1:0]),
        .q       (arith_q)
    );

    psr_sys_flags u_sys (
        .clk         (clk),
        .rst         (rst),
        .wdt_timeout (wdt_timeout),
        .clr_wdt     (clr_wdt),
        .halt        (halt),
        .q           (sys_q)
    );

    assign status = pack_status(sys_q, arith_q);

    // R5
    logic_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && alu_class == 2'd2 && !sw_we) |=> (status[BIT_C] == $past(status[BIT_C])));

    // R3
    sub_borrow_c_chk: assert property (@(posedge clk) disable iff (rst)
        (alu_valid && alu_class == 2'd1 && alu_flag_en[0] && alu_c_out && !sw_we) |=> !status[BIT_C]);

endmodule

// File: tb/test_psr_status_reg.sv
module test_psr_status_reg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       alu_valid = 1'b0;
    logic [1:0] alu_class = 2'd0;
    logic [7:0] alu_result = 8'd0;
    logic       alu_c_out = 1'b0;
    logic       alu_c_nib = 1'b0;
    logic       alu_c_msb = 1'b0;
    logic [3:0] alu_flag_en = 4'd0;
    logic       wdt_timeout = 1'b0;
    logic       clr_wdt = 1'b0;
    logic       halt = 1'b0;
    logic       sw_we = 1'b0;
    logic [7:0] sw_wdata = 8'd0;
    logic [7:0] status;

    always #2 clk = ~clk;

    psr_status_reg i_psr_status_reg (
        .clk(clk), .rst(rst), .alu_valid(alu_valid), .alu_class(alu_class),
        .alu_result(alu_result), .alu_c_out(alu_c_out), .alu_c_nib(alu_c_nib),
        .alu_c_msb(alu_c_msb), .alu_flag_en(alu_flag_en), .wdt_timeout(wdt_timeout),
        .clr_wdt(clr_wdt), .halt(halt), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .status(status)
    );

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    item_t it;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    logic m_c = 0, m_ac = 0, m_z = 0, m_ov = 0, m_pdf = 0, m_to = 0;

    task automatic drive(input logic r, input logic v, input logic [1:0] k,
                         input logic [7:0] res, input logic co, input logic cn,
                         input logic cm, input logic [3:0] en, input logic tev,
                         input logic clr, input logic hlt, input logic we,
                         input logic [7:0] wd, input string tag);
        logic [3:0] msk;
        item_t      e;
        @(negedge clk);
        rst = r; alu_valid = v; alu_class = k; alu_result = res;
        alu_c_out = co; alu_c_nib = cn; alu_c_msb = cm; alu_flag_en = en;
        wdt_timeout = tev; clr_wdt = clr; halt = hlt; sw_we = we; sw_wdata = wd;
        if (r) begin
            {m_c, m_ac, m_z, m_ov, m_pdf, m_to} = '0;
        end else begin
            if (tev) m_to = 1'b1;
            else if (clr || hlt) m_to = 1'b0;
            if (hlt) m_pdf = 1'b1;
            else if (clr) m_pdf = 1'b0;
            if (we) begin
                {m_ov, m_z, m_ac, m_c} = wd[3:0];
            end else if (v) begin
                case (k)
                    2'd0, 2'd1: msk = 4'b1111;
                    2'd2:       msk = 4'b0100;
                    default:    msk = 4'b0001;
                endcase
                msk = msk & en;
                if (msk[0]) m_c  = (k == 2'd1) ? !co : co;
                if (msk[1]) m_ac = (k == 2'd1) ? !cn : cn;
                if (msk[2]) m_z  = (res == 8'd0);
                if (msk[3]) m_ov = cm ^ co;
            end
        end
        e.exp = {2'b00, m_to, m_pdf, m_ov, m_z, m_ac, m_c};
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 0, 0, 0, 8'h00, tag);
    endtask

    // monitor: sample just after the edge that latched the queued stimulus
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            it = q.pop_front();
            checks++;
            if (status !== it.exp) begin
                errors++;
                $display("FAIL %s: status actual=%02h expected=%02h", it.tag, status, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset clears everything
        drive(1, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 0, 0, 0, 8'h00, "R1 reset");
        drive(1, 1, 2'd0, 8'h00, 1, 1, 1, 4'hF, 1, 0, 1, 0, 8'h00, "R1 reset dominates");
        // R2 add: carry out, zero result, overflow
        drive(0, 1, 2'd0, 8'h00, 1, 0, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R2 add carry/ov R4 zero");
        drive(0, 1, 2'd0, 8'h10, 0, 1, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R2 add nibble carry");
        // R3 subtract: inverted borrow
        drive(0, 1, 2'd1, 8'h05, 0, 0, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R3 sub no borrow");
        drive(0, 1, 2'd1, 8'hFF, 1, 1, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R3 sub borrow");
        // R4/R5 logic touches only zero
        drive(0, 1, 2'd2, 8'h00, 1, 1, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R5 logic only zero R4");
        drive(0, 1, 2'd2, 8'h81, 0, 0, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R4 logic nonzero");
        // R5 rotate touches only carry
        drive(0, 1, 2'd3, 8'h00, 1, 1, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R5 rotate carry in");
        drive(0, 1, 2'd3, 8'hFF, 0, 0, 1, 4'hF, 0, 0, 0, 0, 8'h00, "R5 rotate carry out");
        // R6 enables gate and valid low
        drive(0, 1, 2'd0, 8'h00, 1, 1, 1, 4'b0010, 0, 0, 0, 0, 8'h00, "R6 only ac enabled");
        drive(0, 0, 2'd1, 8'h00, 1, 1, 0, 4'hF, 0, 0, 0, 0, 8'h00, "R6 valid low");
        drive(0, 1, 2'd1, 8'h00, 0, 1, 1, 4'b0000, 0, 0, 0, 0, 8'h00, "R6 no enables");
        // R8/R9 system events
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 0, 1, 0, 8'h00, "R8 halt sets pdf");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 1, 0, 0, 0, 8'h00, "R9 timeout sets to");
        // R7 write with upper ones, concurrent ALU op
        drive(0, 1, 2'd0, 8'h00, 1, 1, 1, 4'hF, 0, 0, 0, 1, 8'hF5, "R7 sw write priority");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 0, 0, 1, 8'hCA, "R7 sw write upper ignored");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 1, 1, 0, 0, 8'h00, "R9 timeout beats clear R8");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 1, 0, 0, 8'h00, "R9 clear clears to");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 1, 0, 0, 0, 8'h00, "R9 timeout again");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 0, 1, 0, 8'h00, "R9 halt clears to R8");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 1, 0, 0, 8'h00, "R8 clear clears pdf");
        drive(0, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 1, 1, 0, 8'h00, "R8 halt beats clear");
        idle("R8 hold");
        drive(1, 0, 2'd0, 8'h00, 0, 0, 0, 4'h0, 0, 0, 0, 0, 8'h00, "R1 reset clears pdf");
        idle("R1 idle after reset");
        @(negedge clk);
        wait (q.size() == 0);
        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule